// File: doc/BRIEF.md
# LED Fault Diagnosis Sequencer

This block runs the open/short test of a 16-channel constant-current LED driver and owns its thermal protection state. A start command forces every output channel on for a fixed window of system clock cycles. On the last cycle of that window it samples two comparator inputs per channel, one that flags too little current (open LED or output shorted to ground) and one that flags too much output voltage (shorted LED). It then latches a 16-bit status word in which a 1 marks a healthy channel. A later read command copies that word onto a parallel load bus. The serial shift register of the driver picks the word up from there.

The same block tracks junction temperature through two comparator inputs, a trip threshold and a lower release threshold. Together they form a hysteresis flag. The flag is always visible. When shutdown is enabled, the flag also blanks every output. Commands, the test timer and the read path keep running while the outputs are blanked.

Top module: `led_diag_seq`

## Requirements
- R1: A cycle with `start_test` high makes `test_busy` high from the next cycle on, for exactly WIN cycles, unless a further start arrives.
- R2: While `test_busy` is high and no shutdown is active, `drv_out` is all ones. Otherwise, with no shutdown active, `drv_out` equals `pwm_in`.
- R3: On the last busy cycle, the status word is loaded with one bit per channel. Bit i is 1 when neither `open_cmp[i]` nor `short_cmp[i]` is high in that cycle, and 0 otherwise. Comparator values in any other cycle have no effect.
- R4: A start command during a running test restarts the full WIN-cycle window. The original end of the window updates nothing. A start on the last busy cycle also restarts, and the sample of that cycle is dropped.
- R5: `status_word` is 16'hFFFF after reset. It changes only when a test window completes.
- R6: `shutdown_active` is high exactly when the thermal flag is high and `tsd_en` is high. While it is high, `drv_out` is all zeros, and this overrides the test window.
- R7: `therm_flag` goes high in the cycle after `temp_hot` is high. It goes low in the cycle after `temp_cool` is high while `temp_hot` is low. Otherwise it holds its value, whatever `tsd_en` is.
- R8: A cycle with `read_cmd` high gives `rd_valid` high in the next cycle only. In that cycle `rd_data` holds the status word as it was before the read edge.
- R9: During shutdown, start and read commands are still accepted and test windows still complete and update the status word.
- R10: After reset, `test_busy`, `rd_valid`, `therm_flag` and `shutdown_active` are low. `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_test | input | 1 | Start (or restart) the diagnosis window |
| read_cmd | input | 1 | Copy status word to the load bus |
| pwm_in | input | 16 | Per-channel PWM drive from the grayscale engine |
| open_cmp | input | 16 | 1 = channel current at or below half the programmed value |
| short_cmp | input | 16 | 1 = channel output voltage at or above the short threshold |
| temp_hot | input | 1 | Junction above the trip temperature |
| temp_cool | input | 1 | Junction below the release temperature |
| tsd_en | input | 1 | Thermal shutdown enable |
| drv_out | output | 16 | Channel enables to the current sinks |
| test_busy | output | 1 | Diagnosis window running |
| status_word | output | 16 | Latched health word, 1 = good |
| rd_valid | output | 1 | Load strobe for the serial shift register |
| rd_data | output | 16 | Word to load into the shift register |
| therm_flag | output | 1 | Over-temperature flag |
| shutdown_active | output | 1 | Outputs blanked by thermal shutdown |

## Verification
If the window counter is off by one, `test_busy` ends a cycle early or late. The status word then captures comparator values that were placed on the wrong cycle, and the fault shows at the first test completion. A lost restart shows as a status update WIN cycles after the first start instead of after the second. A wrong hysteresis state shows on `therm_flag` and `drv_out` in the cycle after the temperature inputs change. The bench compares every output against its model on every cycle, so each of these faults appears within one clock of the event.

// File: rtl/led_diag_seq.sv
module led_diag_seq #(
  parameter int CH  = 16,
  parameter int WIN = 100,
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_test,
  input  logic          read_cmd,
  input  logic [CH-1:0] pwm_in,
  input  logic [CH-1:0] open_cmp,
  input  logic [CH-1:0] short_cmp,
  input  logic          temp_hot,
  input  logic          temp_cool,
  input  logic          tsd_en,
  output logic [CH-1:0] drv_out,
  output logic          test_busy,
  output logic [CH-1:0] status_word,
  output logic          rd_valid,
  output logic [CH-1:0] rd_data,
  output logic          therm_flag,
  output logic          shutdown_active
);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = test_busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_busy   <= 1'b0;
      cnt         <= '0;
      status_word <= '1;
    end else if (start_test) begin
      test_busy <= 1'b1;
      cnt       <= CW'(WIN - 1);
    end else if (last) begin
      test_busy   <= 1'b0;
      status_word <= ~(open_cmp | short_cmp);
    end else if (test_busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= read_cmd;
      if (read_cmd) rd_data <= status_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         therm_flag <= 1'b0;
    else if (temp_hot)  therm_flag <= 1'b1;
    else if (temp_cool) therm_flag <= 1'b0;
  end

  assign shutdown_active = therm_flag & tsd_en;
  assign drv_out = shutdown_active ? '0 : (test_busy ? '1 : pwm_in);

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_test |=> test_busy);

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(status_word));

  assert_shut_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_flag && tsd_en) |-> (drv_out == '0));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot |=> therm_flag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_hot && !temp_cool) |=> $stable(therm_flag));

  assert_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_cmd |=> (rd_valid && rd_data == $past(status_word)));

endmodule

// File: tb/sim_led_diag_seq.sv
module sim_led_diag_seq;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_test = 0, read_cmd = 0, temp_hot = 0, temp_cool = 0, tsd_en = 0;
  logic [15:0] pwm_in = 0, open_cmp = 0, short_cmp = 0;
  logic [15:0] drv_out, status_word, rd_data;
  logic test_busy, rd_valid, therm_flag, shutdown_active;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_diag_seq #(.CH(16), .WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .start_test(start_test), .read_cmd(read_cmd),
    .pwm_in(pwm_in), .open_cmp(open_cmp), .short_cmp(short_cmp),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .tsd_en(tsd_en),
    .drv_out(drv_out), .test_busy(test_busy), .status_word(status_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .therm_flag(therm_flag),
    .shutdown_active(shutdown_active));

  // behavioural reference
  int rem = 0;
  bit m_busy = 0, m_rdv = 0, m_flag = 0;
  logic [15:0] m_stat = 16'hFFFF, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; m_busy = 0; m_rdv = 0; m_flag = 0; m_stat = 16'hFFFF; m_rd = 0;
    end else begin
      m_rdv = read_cmd;
      if (read_cmd) m_rd = m_stat;
      if (start_test) begin
        m_busy = 1; rem = WIN;
      end else if (m_busy) begin
        rem = rem - 1;
        if (rem == 0) begin
          m_busy = 0;
          m_stat = ~(open_cmp | short_cmp);
        end
      end
      if (temp_hot) m_flag = 1;
      else if (temp_cool) m_flag = 0;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    logic sd;
    logic [15:0] ed;
    sd = m_flag && tsd_en;
    ed = sd ? 16'h0 : (m_busy ? 16'hFFFF : pwm_in);
    chk("R1 test_busy", {15'b0, test_busy}, {15'b0, m_busy});
    chk("R2 drv_out", drv_out, ed);
    chk("R3 status_word", status_word, m_stat);
    chk("R6 shutdown_active", {15'b0, shutdown_active}, {15'b0, sd});
    chk("R7 therm_flag", {15'b0, therm_flag}, {15'b0, m_flag});
    chk("R8 rd_valid", {15'b0, rd_valid}, {15'b0, m_rdv});
    chk("R8 rd_data", rd_data, m_rd);
  endtask

  int cyc = 0;
  task automatic step();
    @(negedge clk);
    #0.5 compare_all();
    cyc++;
    pwm_in = 16'(cyc * 16'h3B5 ^ 16'hA5C3);
  endtask

  task automatic pulse_start(); start_test = 1; step(); start_test = 0; endtask
  task automatic pulse_read();  read_cmd = 1;  step(); read_cmd = 0;  endtask

  task automatic run_test(logic [15:0] op, logic [15:0] sh);
    int n;
    pulse_start();
    n = 0;
    for (int i = 0; i < WIN - 1; i++) begin
      open_cmp = 16'hFFFF; short_cmp = 16'hFFFF;  // decoys, R3
      if (test_busy) n++;
      step();
    end
    open_cmp = op; short_cmp = sh;
    if (test_busy) n++;
    step();
    open_cmp = 16'hFFFF; short_cmp = 16'h0000;
    checks++;
    if (n != WIN) begin
      errors++;
      $display("FAIL R1 window length: actual %0d expected %0d", n, WIN);
    end
  endtask

  initial begin
    step(); step();
    // R10 reset state
    checks++;
    if (test_busy !== 0 || rd_valid !== 0 || therm_flag !== 0 ||
        shutdown_active !== 0 || rd_data !== 16'h0) begin
      errors++;
      $display("FAIL R10 reset outputs: actual %b%b%b%b %h expected 0000 0000",
               test_busy, rd_valid, therm_flag, shutdown_active, rd_data);
    end
    chk("R5 reset status", status_word, 16'hFFFF);
    rst_n = 1;
    step(); step();
    pulse_read();
    step();
    chk("R8 read of reset word", rd_data, 16'hFFFF);
    run_test(16'h0011, 16'h8200);
    step();
    chk("R3 mixed faults", status_word, ~16'h8211);
    pulse_read(); step();
    // R4 restart mid-window
    pulse_start();
    for (int i = 0; i < 3; i++) step();
    run_test(16'h0000, 16'h0F00);
    chk("R4 restart result", status_word, 16'hF0FF);
    // R4 restart on last cycle
    pulse_start();
    for (int i = 0; i < WIN - 1; i++) step();
    open_cmp = 16'h1234; short_cmp = 0;
    run_test(16'h0001, 16'h0);
    chk("R4 last-cycle restart", status_word, 16'hFFFE);
    run_test(16'h0, 16'h0);
    chk("R3 all good", status_word, 16'hFFFF);
    // R7 flag with shutdown disabled
    temp_hot = 1; step(); temp_hot = 0;
    for (int i = 0; i < 4; i++) step();
    chk("R7 flag holds", {15'b0, therm_flag}, 16'h1);
    temp_cool = 1; temp_hot = 1; step(); temp_hot = 0; step();
    temp_cool = 0; step();
    chk("R7 flag cleared", {15'b0, therm_flag}, 16'h0);
    // R6 / R9 shutdown enabled
    tsd_en = 1;
    temp_hot = 1; step(); temp_hot = 0; step();
    chk("R6 dark", drv_out, 16'h0);
    run_test(16'hC000, 16'h0003);
    chk("R9 test under shutdown", status_word, 16'h3FFC);
    pulse_read(); step();
    chk("R9 read under shutdown", rd_data, 16'h3FFC);
    tsd_en = 0; step(); tsd_en = 1; step();
    temp_cool = 1; step(); temp_cool = 0;
    for (int i = 0; i < 3; i++) step();
    chk("R6 released", {15'b0, shutdown_active}, 16'h0);
    pulse_start(); pulse_read();
    temp_hot = 1; step(); temp_hot = 0;
    for (int i = 0; i < 2 * WIN; i++) step();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule